// File: doc/BRIEF.md
# March Memory Self-Test Controller

This block is a built-in self-test engine for a small single-port synchronous RAM. When it sees a start pulse while idle, it runs a fixed four-pass March sequence over every address of the RAM. It drives the RAM's address, write enable, read enable and write data itself, and it compares every word read back against the value that the algorithm expects at that point. At the end it raises a one-cycle completion pulse. A sticky fail flag reports whether any read mismatched.

On the first mismatch the block records three things: the failing address, the pass in which it happened and the expected bit. These stay put until the next accepted start, so software or a tester can read the diagnosis after completion. The four passes are as follows.
- An initialising pass writes zeros.
- An ascending read-0/write-1 pass follows.
- A descending read-1/write-0 pass comes next.
- A final ascending read-0 pass ends the run.

Together they perform six RAM operations per cell. Read latency is one cycle, so each read is compared in the cycle after it is issued. The write-back to the same cell follows the compare.

Top module: `mbist_march`

## Requirements
- R1: While `rst` (synchronous, active high) is asserted and afterwards until a start is accepted, `done` and `fail` are low and neither `mem_we` nor `mem_re` is asserted.
- R2: An accepted start runs exactly 6·2^ADDR_W RAM operations in this order. Pass 0 writes the all-zero word to addresses 0 up to the highest address. Pass 1 goes through addresses 0 upward and, for each, reads and then writes the all-ones word. Pass 2 goes from the highest address down to 0 (no wrap) and, for each, reads and then writes the all-zero word. Pass 3 reads addresses 0 upward.
- R3: Read data is taken one cycle after `mem_re`. The cycle after a read performs no RAM access (it is the compare cycle). The write-back to the same address comes in the cycle after that. `mem_we` and `mem_re` are never high together.
- R4: `done` is high for exactly one cycle, on the 9·2^ADDR_W-th clock edge after the edge that accepted start.
- R5: A read word that differs in any bit from the expected bit replicated across the word sets `fail` at the edge that ends the compare cycle. It captures `fail_addr`, `fail_elem` (pass number 0 to 3) and `fail_exp`. Later mismatches leave these fields unchanged.
- R6: `fail` and the captured fields hold after `done` until the next accepted start. That start clears `fail` at the edge that accepts it.
- R7: A start pulse during a running test is ignored. The test completes with the same timing and result.
- R8: Asserting `rst` mid-test aborts it. The block returns to idle with `fail` cleared and produces no `done` afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, honoured only when idle |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Sticky mismatch flag |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_elem | output | 2 | Pass number (0 to 3) of the first mismatch |
| fail_exp | output | 1 | Expected bit at the first mismatch |
| mem_addr | output | ADDR_W | RAM address |
| mem_we | output | 1 | RAM write enable |
| mem_re | output | 1 | RAM read enable |
| mem_wdata | output | DATA_W | RAM write data |
| mem_rdata | input | DATA_W | RAM read data, one cycle after `mem_re` |

## Verification
A fault-free RAM never exercises the first-failure capture. The hardest case to reach from the ports is a mismatch that first shows up in the descending pass or in the final read pass, and that is only ever visible if the earlier passes read correctly.

The bench's RAM model injects cell faults of three kinds.
- A stuck-at-1 bit fails in pass 1.
- A stuck-at-0 bit survives pass 1's write and fails in pass 2.
- A cell that cannot fall from 1 to 0 passes everything until pass 3.

For each fault, the expected capture edge is computed from the pass lengths and the sweep direction. A two-fault run then shows that the later mismatches do not overwrite the first.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_WRITE = 3'd1,
    S_READ  = 3'd2,
    S_CMP   = 3'd3,
    S_WB    = 3'd4
  } seq_state_e;

  typedef enum logic [1:0] {
    EL_INIT   = 2'd0,
    EL_UP     = 2'd1,
    EL_DOWN   = 2'd2,
    EL_VERIFY = 2'd3
  } elem_e;

  function automatic logic elem_descending(elem_e e);
    return (e == EL_DOWN);
  endfunction

  function automatic logic elem_has_write(elem_e e);
    return (e != EL_VERIFY);
  endfunction

  function automatic logic elem_read_exp(elem_e e);
    logic v;
    case (e)
      EL_DOWN: v = 1'b1;
      default: v = 1'b0;
    endcase
    return v;
  endfunction

  function automatic logic elem_write_val(elem_e e);
    logic v;
    case (e)
      EL_UP:   v = 1'b1;
      default: v = 1'b0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/mbist_addr_gen.sv
module mbist_addr_gen #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              load_down,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);
  localparam logic [ADDR_W-1:0] ADDR_MAX = {ADDR_W{1'b1}};

  logic down_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr   <= '0;
      down_q <= 1'b0;
    end else if (load) begin
      down_q <= load_down;
      addr   <= load_down ? ADDR_MAX : '0;
    end else if (step && !last) begin
      addr <= down_q ? addr - 1'b1 : addr + 1'b1;
    end
  end

  assign last = down_q ? (addr == '0) : (addr == ADDR_MAX);

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    !(step && last)) else $error("step past sweep end"); // R2

  AST_STEP_DIR: assert property (@(posedge clk) disable iff (rst)
    (step && !load && !last) |=>
      (addr == ($past(down_q) ? $past(addr) - 1'b1 : $past(addr) + 1'b1)))
    else $error("address step wrong"); // R2

endmodule

// File: rtl/mbist_seq.sv
module mbist_seq
  import mbist_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  start,
  input  logic  addr_last,
  output logic  load,
  output logic  load_down,
  output logic  step,
  output logic  busy,
  output logic  mem_we,
  output logic  mem_re,
  output logic  write_bit,
  output logic  check,
  output logic  exp_bit,
  output elem_e elem,
  output logic  done
);
  seq_state_e state_q, state_d;
  elem_e      elem_q, elem_d;
  logic       done_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      elem_q  <= EL_INIT;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      elem_q  <= elem_d;
      done    <= done_d;
    end
  end

  always_comb begin
    state_d   = state_q;
    elem_d    = elem_q;
    load      = 1'b0;
    load_down = 1'b0;
    step      = 1'b0;
    done_d    = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (start) begin
          state_d   = S_WRITE;
          elem_d    = EL_INIT;
          load      = 1'b1;
          load_down = elem_descending(EL_INIT);
        end
      end
      S_WRITE: begin
        if (addr_last) begin
          state_d   = S_READ;
          elem_d    = EL_UP;
          load      = 1'b1;
          load_down = elem_descending(EL_UP);
        end else begin
          step = 1'b1;
        end
      end
      S_READ: state_d = S_CMP;
      S_CMP: begin
        if (elem_has_write(elem_q)) begin
          state_d = S_WB;
        end else if (addr_last) begin
          state_d = S_IDLE;
          done_d  = 1'b1;
        end else begin
          state_d = S_READ;
          step    = 1'b1;
        end
      end
      S_WB: begin
        state_d = S_READ;
        if (addr_last) begin
          elem_d    = elem_e'(elem_q + 2'd1);
          load      = 1'b1;
          load_down = elem_descending(elem_e'(elem_q + 2'd1));
        end else begin
          step = 1'b1;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  assign busy      = (state_q != S_IDLE);
  assign mem_we    = (state_q == S_WRITE) || (state_q == S_WB);
  assign mem_re    = (state_q == S_READ);
  assign check     = (state_q == S_CMP);
  assign write_bit = elem_write_val(elem_q);
  assign exp_bit   = elem_read_exp(elem_q);
  assign elem      = elem_q;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_IDLE) |-> (!mem_we && !mem_re)) else $error("access while idle"); // R1

  AST_READ_THEN_CMP: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_READ) |=> (state_q == S_CMP)) else $error("compare not after read"); // R3

  AST_BUSY_START_IGN: assert property (@(posedge clk) disable iff (rst)
    (busy && start && state_q == S_WRITE && !addr_last) |=> (state_q == S_WRITE && elem_q == EL_INIT))
    else $error("start disturbed run"); // R7

endmodule

// File: rtl/mbist_cmp.sv
module mbist_cmp #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              check,
  input  logic              exp_bit,
  input  logic [DATA_W-1:0] rdata,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        elem,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [1:0]        fail_elem,
  output logic              fail_exp
);
  logic mismatch;

  assign mismatch = check && (rdata != {DATA_W{exp_bit}});

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      fail      <= 1'b0;
      fail_addr <= '0;
      fail_elem <= '0;
      fail_exp  <= 1'b0;
    end else if (mismatch && !fail) begin
      fail      <= 1'b1;
      fail_addr <= addr;
      fail_elem <= elem;
      fail_exp  <= exp_bit;
    end
  end

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (fail && !clear) |=> (fail && $stable(fail_addr) && $stable(fail_elem) && $stable(fail_exp)))
    else $error("first failure overwritten"); // R5

  AST_FAIL_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clear |=> !fail) else $error("fail not cleared by start"); // R6

endmodule

// File: rtl/mbist_march.sv
module mbist_march
  import mbist_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [1:0]        fail_elem,
  output logic              fail_exp,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic  load, load_down, step, busy, addr_last;
  logic  write_bit, check, exp_bit;
  elem_e elem;
  logic [ADDR_W-1:0] addr;

  mbist_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst(rst), .load(load), .load_down(load_down),
    .step(step), .addr(addr), .last(addr_last)
  );

  mbist_seq u_seq (
    .clk(clk), .rst(rst), .start(start), .addr_last(addr_last),
    .load(load), .load_down(load_down), .step(step), .busy(busy),
    .mem_we(mem_we), .mem_re(mem_re), .write_bit(write_bit),
    .check(check), .exp_bit(exp_bit), .elem(elem), .done(done)
  );

  mbist_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
    .clk(clk), .rst(rst), .clear(start && !busy), .check(check),
    .exp_bit(exp_bit), .rdata(mem_rdata), .addr(addr), .elem(elem),
    .fail(fail), .fail_addr(fail_addr), .fail_elem(fail_elem), .fail_exp(fail_exp)
  );

  assign mem_addr  = addr;
  assign mem_wdata = {DATA_W{write_bit}};

  AST_RW_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re)) else $error("read and write together"); // R3

  AST_WB_WAITS: assert property (@(posedge clk) disable iff (rst)
    mem_re |=> (!mem_we && !mem_re)) else $error("access in compare cycle"); // R3

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("done longer than one cycle"); // R4

endmodule

// File: tb/tb_mbist_march.sv
module tb_mbist_march;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int N  = 1 << AW;
  localparam int T  = 9 * N;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic done, fail, fail_exp, mem_we, mem_re;
  logic [AW-1:0] fail_addr, mem_addr;
  logic [1:0] fail_elem;
  logic [DW-1:0] mem_wdata, mem_rdata;

  always #5 clk = ~clk;

  mbist_march #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .start(start), .done(done), .fail(fail),
    .fail_addr(fail_addr), .fail_elem(fail_elem), .fail_exp(fail_exp),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // RAM model with fault injection: kind 0 none, 1 stuck-at-0, 2 stuck-at-1, 3 cannot fall
  logic [DW-1:0] ram [0:N-1];
  int f_kind = 0;
  int f_addr = 0;
  int f_addr2 = -1;
  int f_bit = 0;

  function automatic logic [DW-1:0] apply_fault(int a, logic [DW-1:0] old, logic [DW-1:0] nw);
    logic [DW-1:0] v = nw;
    if (f_kind == 1 && a == f_addr) v[f_bit] = 1'b0;
    if (f_kind == 2 && (a == f_addr || a == f_addr2)) v[f_bit] = 1'b1;
    if (f_kind == 3 && a == f_addr && old[f_bit]) v[f_bit] = 1'b1;
    return v;
  endfunction

  initial begin
    for (int i = 0; i < N; i++) ram[i] = '0;
    mem_rdata = '0;
  end

  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= apply_fault(int'(mem_addr), ram[mem_addr], mem_wdata);
    if (mem_re) mem_rdata <= ram[mem_addr];
  end

  // operation trace
  logic rec = 1'b0;
  int   cyc = 0;
  int   trace_n = 0;
  logic          tr_we [0:127];
  logic [AW-1:0] tr_addr [0:127];
  logic [DW-1:0] tr_wd [0:127];
  int            tr_cyc [0:127];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rec && (mem_we || mem_re)) begin
      if (trace_n < 128) begin
        tr_we[trace_n]   <= mem_we;
        tr_addr[trace_n] <= mem_addr;
        tr_wd[trace_n]   <= mem_wdata;
        tr_cyc[trace_n]  <= cyc;
      end
      trace_n <= trace_n + 1;
    end
  end

  int n_tests = 0;
  int n_fail = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_test(input int pulse_at, output int done_k, output int fail_k, output logic fail0);
    done_k = -1;
    fail_k = -1;
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    fail0 = fail;
    for (int k = 1; k <= T + 40; k++) begin
      @(posedge clk);
      @(negedge clk);
      start = (k == pulse_at);
      if (fail && fail_k < 0) fail_k = k;
      if (done) begin
        done_k = k;
        break;
      end
    end
    start = 1'b0;
  endtask

  task automatic t_reset_state();
    chk("R1", "done in reset", done, 0);
    chk("R1", "fail in reset", fail, 0);
    chk("R1", "access in reset", mem_we | mem_re, 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1", "access idle after reset", mem_we | mem_re, 0);
  endtask

  task automatic t_clean_run();
    int dk, fk;
    logic f0;
    int bad, idx;
    logic          e_we [0:127];
    logic [AW-1:0] e_ad [0:127];
    logic [DW-1:0] e_wd [0:127];
    f_kind = 0;
    idx = 0;
    for (int a = 0; a < N; a++) begin e_we[idx] = 1; e_ad[idx] = AW'(a); e_wd[idx] = '0; idx++; end
    for (int a = 0; a < N; a++) begin
      e_we[idx] = 0; e_ad[idx] = AW'(a); e_wd[idx] = '0; idx++;
      e_we[idx] = 1; e_ad[idx] = AW'(a); e_wd[idx] = '1; idx++;
    end
    for (int a = N - 1; a >= 0; a--) begin
      e_we[idx] = 0; e_ad[idx] = AW'(a); e_wd[idx] = '0; idx++;
      e_we[idx] = 1; e_ad[idx] = AW'(a); e_wd[idx] = '0; idx++;
    end
    for (int a = 0; a < N; a++) begin e_we[idx] = 0; e_ad[idx] = AW'(a); e_wd[idx] = '0; idx++; end
    @(negedge clk); trace_n = 0; rec = 1'b1;
    run_test(-1, dk, fk, f0);
    rec = 1'b0;
    chk("R2", "operation count", trace_n, 6 * N);
    bad = 0;
    for (int i = 0; i < 6 * N && i < trace_n; i++) begin
      if (tr_we[i] !== e_we[i] || tr_addr[i] !== e_ad[i] || (e_we[i] && tr_wd[i] !== e_wd[i])) bad++;
    end
    chk("R2", "operations out of March order", bad, 0);
    bad = 0;
    for (int i = 0; i + 1 < trace_n && i < 127; i++) begin
      if (!tr_we[i] && tr_we[i+1] && (tr_cyc[i+1] - tr_cyc[i] != 2 || tr_addr[i+1] !== tr_addr[i])) bad++;
      if (!tr_we[i] && tr_cyc[i+1] - tr_cyc[i] < 2) bad++;
    end
    chk("R3", "read/compare/write spacing errors", bad, 0);
    chk("R4", "done edge after start", dk, T);
    chk("R5", "fail on clean RAM", fail, 0);
    @(posedge clk); @(negedge clk);
    chk("R4", "done width one cycle", done, 0);
  endtask

  task automatic t_fault(input string name, input int kind, input int a, input int exp_k,
                         input int exp_elem, input int exp_bitv);
    int dk, fk;
    logic f0;
    f_kind = kind; f_addr = a; f_addr2 = -1; f_bit = 3;
    run_test(-1, dk, fk, f0);
    chk("R5", {name, " fail capture edge"}, fk, exp_k);
    chk("R5", {name, " fail_addr"}, fail_addr, a);
    chk("R5", {name, " fail_elem"}, fail_elem, exp_elem);
    chk("R5", {name, " fail_exp"}, fail_exp, exp_bitv);
    chk("R6", {name, " fail held at done"}, fail, 1);
    chk("R4", {name, " done edge"}, dk, T);
    f_kind = 0;
  endtask

  task automatic t_first_only();
    int dk, fk;
    logic f0;
    f_kind = 2; f_addr = 3; f_addr2 = 9; f_bit = 0;
    run_test(-1, dk, fk, f0);
    chk("R5", "two faults: first address kept", fail_addr, 3);
    chk("R5", "two faults: first pass kept", fail_elem, 1);
    repeat (4) @(negedge clk);
    chk("R6", "fail held after done", fail, 1);
    chk("R6", "fail_addr held after done", fail_addr, 3);
    f_kind = 0; f_addr2 = -1;
  endtask

  task automatic t_clear_on_start();
    int dk, fk;
    logic f0;
    chk("R6", "fail set before restart", fail, 1);
    run_test(-1, dk, fk, f0);
    chk("R6", "fail cleared at accepting edge", f0, 0);
    chk("R6", "clean rerun passes", fail, 0);
  endtask

  task automatic t_start_ignored();
    int dk, fk;
    logic f0;
    f_kind = 3; f_addr = 5; f_bit = 1;
    run_test(20, dk, fk, f0);
    chk("R7", "done timing with mid-run start", dk, T);
    chk("R7", "fail edge with mid-run start", fk, 7 * N + 2 * 5 + 2);
    chk("R7", "fail_elem with mid-run start", fail_elem, 3);
    f_kind = 0;
  endtask

  task automatic t_abort();
    int seen;
    f_kind = 2; f_addr = 0; f_addr2 = -1; f_bit = 0;
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    repeat (50) @(negedge clk);
    chk("R8", "fail before abort", fail, 1);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R8", "fail cleared by reset", fail, 0);
    chk("R8", "no access in reset", mem_we | mem_re, 0);
    rst = 1'b0;
    f_kind = 0;
    seen = 0;
    for (int k = 0; k < T + 20; k++) begin
      @(negedge clk);
      if (done || mem_we || mem_re) seen++;
    end
    chk("R8", "activity after abort", seen, 0);
  endtask

  initial begin
    #(200000 * 10);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset_state();
    t_clean_run();
    t_fault("stuck1", 2, 6, N + 3 * 6 + 2, 1, 0);
    t_fault("stuck0", 1, 10, 4 * N + 3 * (N - 1 - 10) + 2, 2, 1);
    t_fault("nofall", 3, 12, 7 * N + 2 * 12 + 2, 3, 0);
    t_first_only();
    t_clear_on_start();
    t_start_ignored();
    t_abort();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule